// File: doc/BRIEF.md
# Paged Program Address Mapper

This block sits between an 8-bit CPU core and program memory. It widens the core's 16-bit logical fetch address into a 22-bit physical ROM address through bank switching. The two top logical bits choose one of four 16K-byte windows. Window 0 is fixed on physical page 0. Windows 1, 2 and 3 each take their physical page from an 8-bit mapping register. The low 14 bits pass through unchanged as the offset inside the page.

Firmware changes the mapping through a small register bus with address, write enable, write data and read data. A configuration input decides whether fetches go to the 512K-byte internal ROM or to the external ROM bus. Every fetch result is registered and marked by a valid flag. An internal fetch that falls outside the internal ROM is flagged as out of range.

Top module: `paged_addr_mapper`

## Requirements
- R1: A fetch whose logical bits [15:14] are 0 always yields physical page 0, whatever the mapping registers hold, with logical bits [13:0] unchanged as physical bits [13:0].
- R2: A fetch in logical window 1, 2 or 3 yields the physical address {page, logical[13:0]}, where page is the mapping register at 0x2C, 0x2D or 0x2E respectively, and the page occupies physical bits [21:14].
- R3: After reset, the registers at 0x2C, 0x2D and 0x2E hold 0x01, 0x02 and 0x03, so a logical address maps to the same physical address.
- R4: A register write is applied at the clock edge where it is accepted. A fetch presented in that same cycle uses the old page, and a fetch in any later cycle uses the new page.
- R5: Read data is registered. One cycle after reg_addr is presented, reg_rdata shows the contents of register 0x2C, 0x2D or 0x2E, or zero for any other address.
- R6: A write to any address other than 0x2C, 0x2D and 0x2E leaves all three mapping registers unchanged.
- R7: phys_valid is high exactly in the cycle after a cycle with fetch_valid high. phys_addr and phys_ext are captured at that edge, and they hold their values while no fetch is requested.
- R8: phys_ext reports the value of cfg_ext_mem sampled together with the fetch (1 means external ROM bus, 0 means internal ROM).
- R9: phys_oor is high exactly when the captured fetch had cfg_ext_mem = 0 and a physical address of at least 0x80000 (512K). It is never high for an external fetch.
- R10: During and directly after reset, phys_valid, phys_addr, phys_ext, phys_oor and reg_rdata are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ext_mem | input | 1 | 1 routes fetches to the external ROM bus |
| fetch_valid | input | 1 | Fetch request strobe |
| fetch_addr | input | 16 | Logical program address |
| reg_addr | input | 8 | Register bus address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| phys_valid | output | 1 | Translated address is valid |
| phys_addr | output | 22 | Physical ROM address |
| phys_ext | output | 1 | Fetch goes to the external ROM |
| phys_oor | output | 1 | Internal fetch beyond internal ROM size |

## Verification
The bench builds the block with its default parameters: a 16-bit logical address, a 14-bit offset, 8-bit pages, a register base of 0x2C and a 512K internal ROM. With these values the last internal page (0x1F), the first out-of-range page (0x20) and the top page (0xFF) can all be programmed. That puts both sides of the out-of-range boundary and the highest 22-bit address within reach. The four-window layout also lets a single test place a fixed window next to all three relocatable ones.

// File: rtl/pam_pkg.sv
package pam_pkg;
  localparam int unsigned DEF_LOG_AW        = 16;
  localparam int unsigned DEF_OFF_W         = 14;
  localparam int unsigned DEF_PAGE_W        = 8;
  localparam int unsigned DEF_REG_AW        = 8;
  localparam int unsigned DEF_REG_BASE      = 'h2C;
  localparam int unsigned DEF_INT_ROM_BYTES = 524288;
endpackage

// File: rtl/pam_page_regs.sv
module pam_page_regs #(
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned REG_AW    = 8,
  parameter int unsigned NUM_RELOC = 3,
  parameter int unsigned REG_BASE  = 'h2C
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [REG_AW-1:0]             reg_addr,
  input  logic                          reg_we,
  input  logic [PAGE_W-1:0]             reg_wdata,
  output logic [PAGE_W-1:0]             reg_rdata,
  output logic [NUM_RELOC*PAGE_W-1:0]   page_flat
);
  logic [NUM_RELOC-1:0] hit;
  logic [PAGE_W-1:0]    rd_next;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_RELOC; gi++) begin : g_win
      assign hit[gi] = (reg_addr == REG_AW'(REG_BASE + gi));
      always_ff @(posedge clk) begin
        if (rst)
          page_flat[gi*PAGE_W +: PAGE_W] <= PAGE_W'(gi + 1);
        else if (reg_we && hit[gi])
          page_flat[gi*PAGE_W +: PAGE_W] <= reg_wdata;
      end
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < NUM_RELOC; k++)
      if (hit[k]) rd_next = page_flat[k*PAGE_W +: PAGE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  // R6: a write that misses every mapping register changes none of them
  assert_stray_write_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_we && (hit == '0)) |=> $stable(page_flat));

  // R5: an address outside the register window reads back as zero
  assert_stray_read_R5: assert property (@(posedge clk) disable iff (rst)
    (hit == '0) |=> (reg_rdata == '0));

  // decoded hits never overlap
  assert_onehot_hit_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));
endmodule

// File: rtl/pam_translate.sv
module pam_translate #(
  parameter int unsigned LOG_AW    = 16,
  parameter int unsigned OFF_W     = 14,
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned NUM_RELOC = 3,
  localparam int unsigned WIN_W    = LOG_AW - OFF_W,
  localparam int unsigned NUM_WIN  = 1 << WIN_W,
  localparam int unsigned PHYS_W   = PAGE_W + OFF_W
) (
  input  logic [LOG_AW-1:0]           log_addr,
  input  logic [NUM_RELOC*PAGE_W-1:0] page_flat,
  output logic [PHYS_W-1:0]           phys_addr
);
  logic [WIN_W-1:0]  win;
  logic [PAGE_W-1:0] page;

  assign win = log_addr[LOG_AW-1:OFF_W];

  // window 0 stays on page 0; others pick their register
  always_comb begin
    page = '0;
    for (int k = 1; k < NUM_WIN; k++)
      if (win == WIN_W'(k)) page = page_flat[(k-1)*PAGE_W +: PAGE_W];
  end

  assign phys_addr = {page, log_addr[OFF_W-1:0]};
endmodule

// File: rtl/pam_out_stage.sv
module pam_out_stage #(
  parameter int unsigned PHYS_W        = 22,
  parameter int unsigned INT_ROM_BYTES = 524288
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_valid,
  input  logic              cfg_ext_mem,
  input  logic [PHYS_W-1:0] phys_next,
  output logic              phys_valid,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              phys_ext,
  output logic              phys_oor
);
  localparam logic [PHYS_W:0] INT_LIMIT = (PHYS_W+1)'(INT_ROM_BYTES);

  logic beyond_int;
  assign beyond_int = ({1'b0, phys_next} >= INT_LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_valid <= 1'b0;
      phys_addr  <= '0;
      phys_ext   <= 1'b0;
      phys_oor   <= 1'b0;
    end else begin
      phys_valid <= fetch_valid;
      if (fetch_valid) begin
        phys_addr <= phys_next;
        phys_ext  <= cfg_ext_mem;
        phys_oor  <= !cfg_ext_mem && beyond_int;
      end
    end
  end

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> phys_valid);
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> (!phys_valid && $stable(phys_addr) && $stable(phys_ext)));
  assert_ext_sampled_R8: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> (phys_ext == $past(cfg_ext_mem)));
  assert_oor_internal_only_R9: assert property (@(posedge clk) disable iff (rst)
    (phys_valid && phys_ext) |-> !phys_oor);
endmodule

// File: rtl/paged_addr_mapper.sv
module paged_addr_mapper
  import pam_pkg::*;
#(
  parameter int unsigned LOG_AW        = DEF_LOG_AW,
  parameter int unsigned OFF_W         = DEF_OFF_W,
  parameter int unsigned PAGE_W        = DEF_PAGE_W,
  parameter int unsigned REG_AW        = DEF_REG_AW,
  parameter int unsigned REG_BASE      = DEF_REG_BASE,
  parameter int unsigned INT_ROM_BYTES = DEF_INT_ROM_BYTES,
  localparam int unsigned WIN_W        = LOG_AW - OFF_W,
  localparam int unsigned NUM_RELOC    = (1 << WIN_W) - 1,
  localparam int unsigned PHYS_W       = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_ext_mem,
  input  logic              fetch_valid,
  input  logic [LOG_AW-1:0] fetch_addr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [PAGE_W-1:0] reg_wdata,
  output logic [PAGE_W-1:0] reg_rdata,
  output logic              phys_valid,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              phys_ext,
  output logic              phys_oor
);
  logic [NUM_RELOC*PAGE_W-1:0] page_flat;
  logic [PHYS_W-1:0]           phys_next;

  pam_page_regs #(
    .PAGE_W(PAGE_W), .REG_AW(REG_AW), .NUM_RELOC(NUM_RELOC), .REG_BASE(REG_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .page_flat(page_flat)
  );

  pam_translate #(
    .LOG_AW(LOG_AW), .OFF_W(OFF_W), .PAGE_W(PAGE_W), .NUM_RELOC(NUM_RELOC)
  ) u_xlate (
    .log_addr(fetch_addr), .page_flat(page_flat), .phys_addr(phys_next)
  );

  pam_out_stage #(
    .PHYS_W(PHYS_W), .INT_ROM_BYTES(INT_ROM_BYTES)
  ) u_out (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .cfg_ext_mem(cfg_ext_mem),
    .phys_next(phys_next), .phys_valid(phys_valid), .phys_addr(phys_addr),
    .phys_ext(phys_ext), .phys_oor(phys_oor)
  );

  // R1: window 0 lands on page 0 with its offset intact
  assert_fixed_window_R1: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && (fetch_addr[LOG_AW-1:OFF_W] == '0)) |=>
      (phys_addr == PHYS_W'($past(fetch_addr[OFF_W-1:0]))));
endmodule

// File: tb/sim_paged_addr_mapper.sv
module sim_paged_addr_mapper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_ext_mem = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        phys_valid;
  logic [21:0] phys_addr;
  logic        phys_ext;
  logic        phys_oor;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_addr_mapper u0 (
    .clk(clk), .rst(rst), .cfg_ext_mem(cfg_ext_mem), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .phys_valid(phys_valid),
    .phys_addr(phys_addr), .phys_ext(phys_ext), .phys_oor(phys_oor)
  );

  // {logical address, expected physical, expected out-of-range}
  // mapping programmed to 0x05 / 0x20 / 0xFF, internal ROM selected
  localparam logic [38:0] VECS [0:9] = '{
    {16'h0000, 22'h000000, 1'b0},
    {16'h3FFF, 22'h003FFF, 1'b0},
    {16'h1234, 22'h001234, 1'b0},
    {16'h4000, 22'h014000, 1'b0},
    {16'h7ABC, 22'h017ABC, 1'b0},
    {16'h5555, 22'h015555, 1'b0},
    {16'h8000, 22'h080000, 1'b1},
    {16'hBFFF, 22'h083FFF, 1'b1},
    {16'hC000, 22'h3FC000, 1'b1},
    {16'hFFFF, 22'h3FFFFF, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_addr = '0;
  endtask

  // one fetch; outputs are sampled at the negedge after the capturing edge
  task automatic fetch(input logic [15:0] a);
    @(negedge clk);
    fetch_addr = a; fetch_valid = 1'b1;
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  initial begin
    logic [7:0]  d;
    logic [21:0] held;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 valid", 32'(phys_valid), 0);
    chk("R10 addr",  32'(phys_addr), 0);
    chk("R10 oor",   32'(phys_oor), 0);
    chk("R10 rdata", 32'(reg_rdata), 0);
    @(negedge clk); rst = 1'b0;

    // R3: reset page values
    rd(8'h2C, d); chk("R3 reg 0x2C", 32'(d), 32'h01);
    rd(8'h2D, d); chk("R3 reg 0x2D", 32'(d), 32'h02);
    rd(8'h2E, d); chk("R3 reg 0x2E", 32'(d), 32'h03);
    fetch(16'h4321); chk("R3 identity w1", 32'(phys_addr), 32'h004321);
    fetch(16'hE000); chk("R3 identity w3", 32'(phys_addr), 32'h00E000);

    // R5: reads outside the window return zero
    rd(8'h2B, d); chk("R5 read 0x2B", 32'(d), 0);
    rd(8'h2F, d); chk("R5 read 0x2F", 32'(d), 0);

    // R6: stray writes change nothing
    wr(8'h2F, 8'hAA); wr(8'h2B, 8'h55); wr(8'h00, 8'h77);
    rd(8'h2C, d); chk("R6 0x2C kept", 32'(d), 32'h01);
    rd(8'h2D, d); chk("R6 0x2D kept", 32'(d), 32'h02);
    rd(8'h2E, d); chk("R6 0x2E kept", 32'(d), 32'h03);
    fetch(16'h8001); chk("R6 mapping kept", 32'(phys_addr), 32'h008001);

    // R5 readback of programmed values
    wr(8'h2C, 8'h05); wr(8'h2D, 8'h20); wr(8'h2E, 8'hFF);
    rd(8'h2C, d); chk("R5 readback 0x2C", 32'(d), 32'h05);
    rd(8'h2D, d); chk("R5 readback 0x2D", 32'(d), 32'h20);
    rd(8'h2E, d); chk("R5 readback 0x2E", 32'(d), 32'hFF);

    // R1 R2 R9: vector table
    for (int i = 0; i < 10; i++) begin
      fetch(VECS[i][38:23]);
      chk("R7 valid",      32'(phys_valid), 1);
      chk("R1/R2 address", 32'(phys_addr), 32'(VECS[i][22:1]));
      chk("R9 oor",        32'(phys_oor), 32'(VECS[i][0]));
      chk("R8 internal",   32'(phys_ext), 0);
    end

    // R7: idle cycle drops valid and holds the address
    held = phys_addr;
    @(negedge clk);
    chk("R7 idle valid", 32'(phys_valid), 0);
    chk("R7 addr held",  32'(phys_addr), 32'(held));

    // R8 R9: external fetch never out of range
    cfg_ext_mem = 1'b1;
    fetch(16'hC000);
    chk("R8 ext", 32'(phys_ext), 1);
    chk("R9 ext no oor", 32'(phys_oor), 0);
    chk("R2 ext addr", 32'(phys_addr), 32'h3FC000);
    cfg_ext_mem = 1'b0;
    fetch(16'hC000);
    chk("R8 back to internal", 32'(phys_ext), 0);

    // R9: last internal page sits below the limit
    wr(8'h2D, 8'h1F);
    fetch(16'hBFFF);
    chk("R9 page 0x1F addr", 32'(phys_addr), 32'h07FFFF);
    chk("R9 page 0x1F oor", 32'(phys_oor), 0);

    // R1: window 0 stays on page 0 while others are remapped
    fetch(16'h2ABC);
    chk("R1 window 0", 32'(phys_addr), 32'h002ABC);

    // R4: write and fetch in the same cycle, then fetch again
    @(negedge clk);
    reg_addr = 8'h2C; reg_wdata = 8'h07; reg_we = 1'b1;
    fetch_addr = 16'h4000; fetch_valid = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = '0;
    chk("R4 same cycle old page", 32'(phys_addr), 32'h014000);
    @(negedge clk);
    fetch_valid = 1'b0;
    chk("R4 next cycle new page", 32'(phys_addr), 32'h01C000);

    // R10: reset mid-run clears outputs and restores pages
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R10 addr after reset", 32'(phys_addr), 0);
    chk("R10 valid after reset", 32'(phys_valid), 0);
    rst = 1'b0;
    rd(8'h2C, d); chk("R3 0x2C after reset", 32'(d), 32'h01);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule